// File: doc/BRIEF.md
# Supply Level Classifier and Brown-out Monitor

This block watches a digitised supply voltage. A converter outside the block delivers unsigned millivolt codes with a one-cycle valid strobe. Each valid sample is sorted into one of five battery classes, using four falling thresholds at 2.7 V, 2.5 V, 2.3 V and 2.1 V. A new class is adopted only after it has been seen on four valid samples in a row, which keeps noise near a threshold from toggling the reported code. A sticky low-battery interrupt flag sets whenever the reported class moves toward a lower voltage. Software clears it with a write-one acknowledge.

A separate brown-out detector compares the same samples against a 1.73 V entry threshold and a 1.79 V release threshold. The gap between the two gives hysteresis. Its registered reset request stays high for as long as the brown-out condition holds. The detector is off after reset and does nothing until software sets its enable bit. Clearing the enable bit forces it back to the idle state. The intended supply range is 1.7 V to 3.6 V, and the default 12-bit code width covers it.

Top module: `supply_monitor`

## Requirements
- R1: After reset, `level_code` is 0, `lowbat_irq` is 0, `bod_rst_req` is 0 and brown-out detection is disabled.
- R2: A valid sample maps to a class as follows. At or above 2700 mV it is class 0. From 2500 to 2699 it is 1, from 2300 to 2499 it is 2, and from 2100 to 2299 it is 3. Below 2100 it is 4. A sample exactly at a threshold belongs to the higher-voltage class.
- R3: `level_code` takes a new class on the clock edge that registers the fourth consecutive valid sample of that class. A valid sample of the current class, or of another class, restarts the count. Cycles with `smp_vld` low neither count nor break the run.
- R4: `lowbat_irq` sets on the same edge on which `level_code` increases. A decrease does not set it.
- R5: A write with `reg_addr`=1 and `reg_wdata`=1 clears `lowbat_irq` on that edge. If it coincides with an increase of `level_code`, the flag stays set. A write of 0 to address 1 has no effect.
- R6: A write to `reg_addr`=0 loads `reg_wdata` as the brown-out enable, effective on that edge. While the enable is 0, `bod_rst_req` is 0 whatever the samples are.
- R7: With the enable at 1, a valid sample below 1730 mV drives `bod_rst_req` high on the next edge.
- R8: With the enable at 1, `bod_rst_req` keeps its value for samples from 1730 to 1790 mV inclusive. It falls on the edge after a valid sample above 1790 mV.
- R9: Writing the enable to 0 while `bod_rst_req` is high clears it on that same edge. A later re-enable starts from the released state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_mv | input | 12 | Supply sample in millivolts, unsigned |
| smp_vld | input | 1 | Sample strobe, one cycle per sample |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0: brown-out enable, 1: interrupt acknowledge |
| reg_wdata | input | 1 | Write data bit |
| level_code | output | 3 | Filtered battery class, 0 (full) to 4 (lowest) |
| lowbat_irq | output | 1 | Sticky low-battery interrupt flag |
| bod_rst_req | output | 1 | Brown-out reset request, level |

## Verification
Every result of this block appears one edge after its cause. A class change shows on `level_code` right after the edge that takes the fourth matching sample, and the interrupt rises with it. An acknowledge or an enable write acts on the edge of the write. A brown-out entry or release shows one edge after the deciding sample. The bench drives inputs on the falling clock edge and updates a behavioural model on the rising edge. It compares all three outputs at the following falling edge, so each expected value is read exactly one register stage after its stimulus. Directed checks at threshold values, at interrupted runs and at coinciding set and acknowledge sit on top of the per-cycle comparison.

// File: rtl/smon_pkg.sv
package smon_pkg;
  localparam int unsigned NUM_LVL = 4;
  localparam int unsigned LVL_W   = $clog2(NUM_LVL + 1);

  typedef enum logic {
    REG_BOD_EN  = 1'b0,
    REG_IRQ_ACK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/smon_classify.sv
module smon_classify
  import smon_pkg::*;
#(
  parameter int unsigned MV_W = 12,
  parameter int unsigned THR_MV [NUM_LVL] = '{2700, 2500, 2300, 2100}
) (
  input  logic [MV_W-1:0]  mv,
  output logic [LVL_W-1:0] cls
);
  logic [NUM_LVL-1:0] below;

  genvar g;
  generate
    for (g = 0; g < NUM_LVL; g++) begin : g_cmp
      assign below[g] = (mv < MV_W'(THR_MV[g]));
    end
  endgenerate

  // thresholds descend, so the number of thresholds above the sample is the class
  always_comb begin
    cls = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      cls = cls + LVL_W'(below[i]);
    end
  end
endmodule

// File: rtl/smon_filter.sv
module smon_filter
  import smon_pkg::*;
#(
  parameter int unsigned RUN_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [LVL_W-1:0] cls,
  output logic [LVL_W-1:0] level_q,
  output logic             lvl_up
);
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);

  logic [LVL_W-1:0] cand_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_new;
  logic             same_lvl;
  logic             hit;
  logic             upd;

  assign same_lvl = (cls == level_q);
  assign hit      = (cls == cand_q) && (cnt_q != '0);
  assign cnt_new  = hit ? cnt_q + CNT_W'(1) : CNT_W'(1);
  assign upd      = vld && !same_lvl && (cnt_new == CNT_W'(RUN_LEN));
  assign lvl_up   = upd && (cls > level_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      cand_q  <= '0;
      cnt_q   <= '0;
    end else if (vld) begin
      cand_q <= cls;
      if (same_lvl || upd) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_new;
      end
      if (upd) begin
        level_q <= cls;
      end
    end
  end

  p_code_range_r2: assert property (@(posedge clk) disable iff (rst)
    level_q <= LVL_W'(NUM_LVL));
  p_hold_no_sample_r3: assert property (@(posedge clk) disable iff (rst)
    !vld |=> $stable(level_q));
endmodule

// File: rtl/smon_regs.sv
module smon_regs
  import smon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic reg_we,
  input  logic reg_addr,
  input  logic reg_wdata,
  input  logic lvl_up,
  output logic en_nxt,
  output logic irq_q
);
  logic en_q;
  logic ack;

  assign en_nxt = (reg_we && reg_addr == REG_BOD_EN) ? reg_wdata : en_q;
  assign ack    = reg_we && (reg_addr == REG_IRQ_ACK) && reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      en_q <= en_nxt;
      if (lvl_up) begin
        irq_q <= 1'b1;
      end else if (ack) begin
        irq_q <= 1'b0;
      end
    end
  end

  p_irq_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
    lvl_up |=> irq_q);
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (ack && !lvl_up) |=> !irq_q);
endmodule

// File: rtl/smon_brownout.sv
module smon_brownout #(
  parameter int unsigned MV_W     = 12,
  parameter int unsigned ENTER_MV = 1730,
  parameter int unsigned LEAVE_MV = 1790
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_nxt,
  input  logic            vld,
  input  logic [MV_W-1:0] mv,
  output logic            bod_q
);
  logic enter;
  logic leave;

  assign enter = vld && (mv < MV_W'(ENTER_MV));
  assign leave = vld && (mv > MV_W'(LEAVE_MV));

  always_ff @(posedge clk) begin
    if (rst || !en_nxt) begin
      bod_q <= 1'b0;
    end else if (enter) begin
      bod_q <= 1'b1;
    end else if (leave) begin
      bod_q <= 1'b0;
    end
  end

  p_off_when_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    !en_nxt |=> !bod_q);
  p_enter_r7: assert property (@(posedge clk) disable iff (rst)
    (en_nxt && vld && mv < MV_W'(ENTER_MV)) |=> bod_q);
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    (en_nxt && vld && mv > MV_W'(LEAVE_MV)) |=> !bod_q);
  p_band_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (en_nxt && !(vld && (mv < MV_W'(ENTER_MV) || mv > MV_W'(LEAVE_MV)))) |=> $stable(bod_q));
endmodule

// File: rtl/supply_monitor.sv
module supply_monitor
  import smon_pkg::*;
#(
  parameter int unsigned MV_W     = 12,
  parameter int unsigned THR_MV [NUM_LVL] = '{2700, 2500, 2300, 2100},
  parameter int unsigned RUN_LEN  = 4,
  parameter int unsigned ENTER_MV = 1730,
  parameter int unsigned LEAVE_MV = 1790
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MV_W-1:0]  smp_mv,
  input  logic             smp_vld,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic             reg_wdata,
  output logic [LVL_W-1:0] level_code,
  output logic             lowbat_irq,
  output logic             bod_rst_req
);
  logic [LVL_W-1:0] cls;
  logic             lvl_up;
  logic             en_nxt;

  smon_classify #(.MV_W(MV_W), .THR_MV(THR_MV)) u_cls (
    .mv  (smp_mv),
    .cls (cls)
  );

  smon_filter #(.RUN_LEN(RUN_LEN)) u_flt (
    .clk     (clk),
    .rst     (rst),
    .vld     (smp_vld),
    .cls     (cls),
    .level_q (level_code),
    .lvl_up  (lvl_up)
  );

  smon_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .lvl_up    (lvl_up),
    .en_nxt    (en_nxt),
    .irq_q     (lowbat_irq)
  );

  smon_brownout #(.MV_W(MV_W), .ENTER_MV(ENTER_MV), .LEAVE_MV(LEAVE_MV)) u_bod (
    .clk    (clk),
    .rst    (rst),
    .en_nxt (en_nxt),
    .vld    (smp_vld),
    .mv     (smp_mv),
    .bod_q  (bod_rst_req)
  );
endmodule

// File: tb/test_supply_monitor.sv
module test_supply_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] smp_mv = '0;
  logic        smp_vld = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic        reg_wdata = 1'b0;
  logic [2:0]  level_code;
  logic        lowbat_irq;
  logic        bod_rst_req;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  int m_lvl = 0, m_cand = 0, m_cnt = 0;
  int m_irq = 0, m_en = 0, m_bod = 0;

  always #2 clk = ~clk;

  supply_monitor i_supply_monitor (
    .clk(clk), .rst(rst), .smp_mv(smp_mv), .smp_vld(smp_vld),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .level_code(level_code), .lowbat_irq(lowbat_irq), .bod_rst_req(bod_rst_req)
  );

  function automatic int ref_class(input int mv);
    if (mv >= 2700) return 0;
    if (mv >= 2500) return 1;
    if (mv >= 2300) return 2;
    if (mv >= 2100) return 3;
    return 4;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_lvl = 0; m_cand = 0; m_cnt = 0; m_irq = 0; m_en = 0; m_bod = 0;
    end else begin
      int c;
      int en_n;
      bit up;
      up = 1'b0;
      en_n = m_en;
      if (reg_we && !reg_addr) en_n = reg_wdata;
      if (smp_vld) begin
        c = ref_class(int'(smp_mv));
        if (c == m_lvl) m_cnt = 0;
        else begin
          if (c == m_cand && m_cnt > 0) m_cnt++;
          else begin m_cand = c; m_cnt = 1; end
          if (m_cnt == 4) begin
            up = (c > m_lvl);
            m_lvl = c;
            m_cnt = 0;
          end
        end
      end
      if (up) m_irq = 1;
      else if (reg_we && reg_addr && reg_wdata) m_irq = 0;
      if (en_n == 0) m_bod = 0;
      else if (smp_vld) begin
        if (smp_mv < 1730) m_bod = 1;
        else if (smp_mv > 1790) m_bod = 0;
      end
      m_en = en_n;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R3 level_code vs model", int'(level_code), m_lvl);
      check("R4 lowbat_irq vs model", int'(lowbat_irq), m_irq);
      check("R7 bod_rst_req vs model", int'(bod_rst_req), m_bod);
    end
  end

  task automatic put(input int mv, input bit v);
    @(negedge clk);
    smp_mv = 12'(mv); smp_vld = v; reg_we = 1'b0;
  endtask

  task automatic put_n(input int mv, input int n);
    for (int i = 0; i < n; i++) put(mv, 1'b1);
  endtask

  task automatic wr(input bit a, input bit d);
    @(negedge clk);
    smp_vld = 1'b0; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    smp_vld = 1'b0; reg_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    idle();
    check("R1 reset level", int'(level_code), 0);
    check("R1 reset irq", int'(lowbat_irq), 0);
    check("R1 reset bod", int'(bod_rst_req), 0);
    put_n(1600, 2); idle();
    check("R1 bod off after reset", int'(bod_rst_req), 0);
    put_n(3000, 5); idle();
    check("R2 full class", int'(level_code), 0);

    put_n(2600, 3); idle();
    check("R3 three samples not enough", int'(level_code), 0);
    put_n(2600, 1); idle();
    check("R2 class 1", int'(level_code), 1);
    check("R4 irq on rise", int'(lowbat_irq), 1);
    wr(1'b1, 1'b0); idle();
    check("R5 write zero no effect", int'(lowbat_irq), 1);
    wr(1'b1, 1'b1); idle();
    check("R5 ack clears", int'(lowbat_irq), 0);

    put_n(2400, 2); put(2600, 1'b1); put_n(2400, 3); idle();
    check("R3 run broken by current class", int'(level_code), 1);
    put_n(2400, 1); idle();
    check("R3 class 2 after full run", int'(level_code), 2);
    put_n(2200, 2); put(2000, 1'b1); put_n(2200, 3); idle();
    check("R3 run broken by other class", int'(level_code), 2);
    wr(1'b1, 1'b1);
    put(2200, 1'b1); put(0, 1'b0); put(2200, 1'b1); put(0, 1'b0); put(0, 1'b0);
    put(2200, 1'b1); put(0, 1'b0); put(2200, 1'b1); idle();
    check("R3 gaps do not break run", int'(level_code), 3);
    put_n(2100, 4); idle();
    check("R2 exactly 2100 is class 3", int'(level_code), 3);
    put_n(2099, 4); idle();
    check("R2 2099 is class 4", int'(level_code), 4);
    wr(1'b1, 1'b1); idle();
    put_n(2700, 4); idle();
    check("R2 exactly 2700 is class 0", int'(level_code), 0);
    check("R4 no irq on fall", int'(lowbat_irq), 0);
    put_n(2500, 4); idle();
    check("R2 exactly 2500 is class 1", int'(level_code), 1);
    put_n(2300, 3);
    @(negedge clk);
    smp_mv = 12'd2300; smp_vld = 1'b1; reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 1'b1;
    idle();
    check("R2 exactly 2300 is class 2", int'(level_code), 2);
    check("R5 set wins over ack", int'(lowbat_irq), 1);

    put_n(1600, 3); idle();
    check("R6 disabled ignores low", int'(bod_rst_req), 0);
    wr(1'b0, 1'b1);
    put(1730, 1'b1); idle();
    check("R7 1730 does not enter", int'(bod_rst_req), 0);
    put(1729, 1'b1); idle();
    check("R7 1729 enters", int'(bod_rst_req), 1);
    put(1790, 1'b1); put(1760, 1'b1); idle();
    check("R8 band holds", int'(bod_rst_req), 1);
    put(1791, 1'b1); idle();
    check("R8 1791 releases", int'(bod_rst_req), 0);
    put(1760, 1'b1); idle();
    check("R8 band keeps released", int'(bod_rst_req), 0);
    put(1700, 1'b1); idle();
    check("R7 re-enter", int'(bod_rst_req), 1);
    @(negedge clk);
    smp_mv = 12'd1600; smp_vld = 1'b1; reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = 1'b0;
    idle();
    check("R9 disable clears same edge", int'(bod_rst_req), 0);
    put_n(1600, 2); idle();
    check("R6 stays low while disabled", int'(bod_rst_req), 0);
    wr(1'b0, 1'b1);
    put(1760, 1'b1); idle();
    check("R9 re-enable starts released", int'(bod_rst_req), 0);
    put_n(3300, 4); idle();
    check("R3 back to class 0", int'(level_code), 0);
    repeat (3) idle();
    finish_run();
  end
endmodule